// File: doc/BRIEF.md
# Snooping MESI Line Controller

This block is the coherence engine of a write-back outer cache that sits on a snooped system bus beside other caches. It keeps a small direct-mapped array of lines, each holding a tag and a two-bit MESI state. It serves three sources: write-through and read requests from a write-once inner cache, addresses snooped from other bus masters, and acknowledges from the bus for its own fills and writes. Only one transaction is in flight at a time. Data storage, victim eviction and bus arbitration live outside the block.

The controller answers snoops with hit and hit-modified outputs. When a snoop lands on a Modified line it raises back-off toward the requesting master. It then asks the inner cache to flush its newer copy, writes the line to memory, moves the line to its new state and drops back-off. On the local side, a write-through that hits an Exclusive line makes the line Modified and tells the inner cache to switch that line to write-back. A write to a Shared line is sent to memory, and the line becomes Exclusive. A write miss goes straight to memory without allocating a line.

The sequencer has five states:
- IDLE: accepts a snoop, or a local request when no snoop is present.
- FILL: a read miss waits for the bus.
- WRITE: a write-through or write-by waits for the bus.
- FLUSH: back-off is held while the inner cache flushes.
- WBACK: back-off is held while the line is written to memory.

The transitions are:
- IDLE to FILL on a local read miss.
- IDLE to WRITE on a local write to a Shared or Invalid line.
- IDLE to FLUSH on a snoop that hits a Modified line.
- FLUSH to WBACK on the inner acknowledge.
- FILL, WRITE and WBACK each return to IDLE on the bus acknowledge.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid. A local read then starts a bus read (`bus_rd`), and a snoop gets no hit.
- R2: A read miss finishes when `bus_ack` arrives. The line is filled as Exclusive when `bus_shared` is low with that acknowledge, and as Shared when it is high.
- R3: A snooped read that hits an Exclusive line asserts `snp_hit` without `snp_hitm` or back-off, in the snoop cycle. The line becomes Shared.
- R4: A snooped read that hits a Modified line asserts `snp_hit` and `snp_hitm` and raises `backoff` on the next cycle. Back-off holds through these steps, in order: `in_cmd` = 1 (flush and keep shared) until `in_ack`, then `bus_wr` to the snooped address until `bus_ack`. Back-off then drops and the line is Shared.
- R5: A snooped write that hits an Exclusive or Shared line asserts `snp_hit` and drives `in_cmd` = 3 (invalidate) with `in_addr` set to the snooped address, in the snoop cycle, with no back-off. The line becomes Invalid.
- R6: A snooped write that hits a Modified line follows the R4 sequence with `in_cmd` = 2 (flush and invalidate). Both levels end Invalid.
- R7: A local write that hits an Exclusive line completes in the request cycle. It drives `in_cmd` = 4 (switch to write-back), issues no bus command, and the line becomes Modified.
- R8: A local write that hits a Shared line drives `bus_wr` and completes on `bus_ack`. The line becomes Exclusive.
- R9: A local write miss drives `bus_wr` and completes on `bus_ack`. No line is allocated; the line stays Invalid.
- R10: While `backoff` is high, `loc_ready` and `loc_done` stay low and no local request is taken.
- R11: A snoop whose address matches no valid tag asserts neither hit output, issues no inner command, and leaves every line unchanged.
- R12: A local read that hits a valid line completes in the request cycle with no bus command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| loc_req | input | 1 | Local request from the inner cache |
| loc_we | input | 1 | Local request is a write (1) or a read (0) |
| loc_addr | input | ADDR_W | Local request line address |
| loc_ready | output | 1 | A local request is taken at this edge |
| loc_done | output | 1 | The local request completes this cycle |
| snp_valid | input | 1 | A snooped bus address is present (one cycle) |
| snp_we | input | 1 | The snooped access is a write |
| snp_addr | input | ADDR_W | Snooped line address |
| snp_hit | output | 1 | The snoop hits a valid line |
| snp_hitm | output | 1 | The snoop hits a Modified line |
| backoff | output | 1 | Back-off request to the current bus master |
| bus_rd | output | 1 | Bus line read (fill) request |
| bus_wr | output | 1 | Bus memory write (write-through, write-by or write-back) |
| bus_addr | output | ADDR_W | Address of the bus command |
| bus_ack | input | 1 | Bus completes the current command |
| bus_shared | input | 1 | Another cache signalled hit on our read; valid with bus_ack |
| in_cmd | output | 3 | Inner command: 0 none, 1 flush and share, 2 flush and invalidate, 3 invalidate, 4 switch to write-back |
| in_addr | output | ADDR_W | Line address of the inner command |
| in_ack | input | 1 | Inner cache has finished a flush |

## Verification
The assertions assume the following about the environment:
- `snp_valid` pulses for one cycle, and only while the controller is idle. The controller is never the bus master while it is being snooped.
- `bus_ack` arrives only while a bus command is pending.
- `in_ack` arrives only during a flush.
- A read miss never lands on a slot that holds a Modified victim.

The bench keeps within these rules:
- Every snoop is issued after the previous task has brought the sequencer back to IDLE.
- Acknowledges are raised only after the matching command has been observed.
- Each test address uses its own line index.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

    typedef enum logic [1:0] {
        MESI_I = 2'd0,
        MESI_S = 2'd1,
        MESI_E = 2'd2,
        MESI_M = 2'd3
    } mesi_t;

    typedef enum logic [2:0] {
        ICMD_NONE       = 3'd0,
        ICMD_FLUSH_KEEP = 3'd1,
        ICMD_FLUSH_DROP = 3'd2,
        ICMD_INVAL      = 3'd3,
        ICMD_WBMODE     = 3'd4
    } icmd_t;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_FILL,
        SQ_WRITE,
        SQ_FLUSH,
        SQ_WBACK
    } seq_t;

endpackage

// File: rtl/mesi_tag_array.sv
module mesi_tag_array
    import mesi_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int NUM_LINES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] lka_addr,
    output mesi_t             lka_st,
    input  logic [ADDR_W-1:0] lkb_addr,
    output mesi_t             lkb_st,
    input  logic              upd_en,
    input  logic [ADDR_W-1:0] upd_addr,
    input  mesi_t             upd_st
);
    localparam int IDX_W = $clog2(NUM_LINES);
    localparam int TAG_W = ADDR_W - IDX_W;

    logic [NUM_LINES-1:0][TAG_W-1:0] tag_v;
    logic [NUM_LINES-1:0][1:0]       st_v;

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        logic [TAG_W-1:0] tag_r;
        mesi_t            st_r;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                tag_r <= '0;
                st_r  <= MESI_I;
            end else if (upd_en && upd_addr[IDX_W-1:0] == IDX_W'(g)) begin
                tag_r <= upd_addr[ADDR_W-1:IDX_W];
                st_r  <= upd_st;
            end
        end
        assign tag_v[g] = tag_r;
        assign st_v[g]  = st_r;
    end

    always_comb begin
        lka_st = MESI_I;
        if (st_v[lka_addr[IDX_W-1:0]] != 2'd0 &&
            tag_v[lka_addr[IDX_W-1:0]] == lka_addr[ADDR_W-1:IDX_W])
            lka_st = mesi_t'(st_v[lka_addr[IDX_W-1:0]]);
    end

    always_comb begin
        lkb_st = MESI_I;
        if (st_v[lkb_addr[IDX_W-1:0]] != 2'd0 &&
            tag_v[lkb_addr[IDX_W-1:0]] == lkb_addr[ADDR_W-1:IDX_W])
            lkb_st = mesi_t'(st_v[lkb_addr[IDX_W-1:0]]);
    end

endmodule

// File: rtl/mesi_seq.sv
module mesi_seq
    import mesi_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              loc_req,
    input  logic              loc_we,
    input  logic [ADDR_W-1:0] loc_addr,
    input  mesi_t             loc_st,
    input  logic              snp_valid,
    input  logic              snp_we,
    input  logic [ADDR_W-1:0] snp_addr,
    input  mesi_t             snp_st,
    input  logic              bus_ack,
    input  logic              bus_shared,
    input  logic              in_ack,
    output logic              upd_en,
    output logic [ADDR_W-1:0] upd_addr,
    output mesi_t             upd_st,
    output logic              loc_ready,
    output logic              loc_done,
    output logic              snp_hit,
    output logic              snp_hitm,
    output logic              backoff,
    output logic              bus_rd,
    output logic              bus_wr,
    output logic [ADDR_W-1:0] bus_addr,
    output icmd_t             in_cmd,
    output logic [ADDR_W-1:0] in_addr
);
    seq_t              st, nxt;
    logic [ADDR_W-1:0] op_addr;
    logic              op_we;
    logic              op_up;

    // State and operation capture register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st      <= SQ_IDLE;
            op_addr <= '0;
            op_we   <= 1'b0;
            op_up   <= 1'b0;
        end else begin
            st <= nxt;
            if (st == SQ_IDLE && (snp_valid || loc_req)) begin
                op_addr <= snp_valid ? snp_addr : loc_addr;
                op_we   <= snp_valid ? snp_we : loc_we;
                op_up   <= !snp_valid && (loc_st == MESI_S);
            end
        end
    end

    // Next state and outputs
    always_comb begin
        nxt       = st;
        upd_en    = 1'b0;
        upd_addr  = op_addr;
        upd_st    = MESI_I;
        loc_ready = 1'b0;
        loc_done  = 1'b0;
        snp_hit   = 1'b0;
        snp_hitm  = 1'b0;
        backoff   = 1'b0;
        bus_rd    = 1'b0;
        bus_wr    = 1'b0;
        bus_addr  = op_addr;
        in_cmd    = ICMD_NONE;
        in_addr   = op_addr;
        unique case (st)
            SQ_IDLE: begin
                loc_ready = !snp_valid;
                in_addr   = snp_valid ? snp_addr : loc_addr;
                if (snp_valid) begin
                    upd_addr = snp_addr;
                    if (snp_st != MESI_I) snp_hit = 1'b1;
                    if (snp_st == MESI_M) begin
                        snp_hitm = 1'b1;
                        nxt      = SQ_FLUSH;
                    end else if (snp_st != MESI_I) begin
                        if (snp_we) begin
                            upd_en = 1'b1;
                            upd_st = MESI_I;
                            in_cmd = ICMD_INVAL;
                        end else if (snp_st == MESI_E) begin
                            upd_en = 1'b1;
                            upd_st = MESI_S;
                        end
                    end
                end else if (loc_req) begin
                    upd_addr = loc_addr;
                    if (!loc_we) begin
                        if (loc_st != MESI_I) loc_done = 1'b1;
                        else                  nxt = SQ_FILL;
                    end else if (loc_st == MESI_E || loc_st == MESI_M) begin
                        loc_done = 1'b1;
                        upd_en   = 1'b1;
                        upd_st   = MESI_M;
                        in_cmd   = ICMD_WBMODE;
                    end else begin
                        nxt = SQ_WRITE;
                    end
                end
            end
            SQ_FILL: begin
                bus_rd = 1'b1;
                if (bus_ack) begin
                    upd_en   = 1'b1;
                    upd_st   = bus_shared ? MESI_S : MESI_E;
                    loc_done = 1'b1;
                    nxt      = SQ_IDLE;
                end
            end
            SQ_WRITE: begin
                bus_wr = 1'b1;
                if (bus_ack) begin
                    loc_done = 1'b1;
                    nxt      = SQ_IDLE;
                    if (op_up) begin
                        upd_en = 1'b1;
                        upd_st = MESI_E;
                    end
                end
            end
            SQ_FLUSH: begin
                backoff  = 1'b1;
                snp_hit  = 1'b1;
                snp_hitm = 1'b1;
                in_cmd   = op_we ? ICMD_FLUSH_DROP : ICMD_FLUSH_KEEP;
                if (in_ack) nxt = SQ_WBACK;
            end
            SQ_WBACK: begin
                backoff  = 1'b1;
                snp_hit  = 1'b1;
                snp_hitm = 1'b1;
                bus_wr   = 1'b1;
                if (bus_ack) begin
                    upd_en = 1'b1;
                    upd_st = op_we ? MESI_I : MESI_S;
                    nxt    = SQ_IDLE;
                end
            end
            default: nxt = SQ_IDLE;
        endcase
    end

endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
    import mesi_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int NUM_LINES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              loc_req,
    input  logic              loc_we,
    input  logic [ADDR_W-1:0] loc_addr,
    output logic              loc_ready,
    output logic              loc_done,
    input  logic              snp_valid,
    input  logic              snp_we,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              snp_hit,
    output logic              snp_hitm,
    output logic              backoff,
    output logic              bus_rd,
    output logic              bus_wr,
    output logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_ack,
    input  logic              bus_shared,
    output logic [2:0]        in_cmd,
    output logic [ADDR_W-1:0] in_addr,
    input  logic              in_ack
);
    mesi_t             loc_st, snp_st, upd_st;
    logic              upd_en;
    logic [ADDR_W-1:0] upd_addr;
    icmd_t             icmd;

    mesi_tag_array #(
        .ADDR_W    (ADDR_W),
        .NUM_LINES (NUM_LINES)
    ) u_tags (
        .clk      (clk),
        .rst_n    (rst_n),
        .lka_addr (loc_addr),
        .lka_st   (loc_st),
        .lkb_addr (snp_addr),
        .lkb_st   (snp_st),
        .upd_en   (upd_en),
        .upd_addr (upd_addr),
        .upd_st   (upd_st)
    );

    mesi_seq #(
        .ADDR_W (ADDR_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .loc_req    (loc_req),
        .loc_we     (loc_we),
        .loc_addr   (loc_addr),
        .loc_st     (loc_st),
        .snp_valid  (snp_valid),
        .snp_we     (snp_we),
        .snp_addr   (snp_addr),
        .snp_st     (snp_st),
        .bus_ack    (bus_ack),
        .bus_shared (bus_shared),
        .in_ack     (in_ack),
        .upd_en     (upd_en),
        .upd_addr   (upd_addr),
        .upd_st     (upd_st),
        .loc_ready  (loc_ready),
        .loc_done   (loc_done),
        .snp_hit    (snp_hit),
        .snp_hitm   (snp_hitm),
        .backoff    (backoff),
        .bus_rd     (bus_rd),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .in_cmd     (icmd),
        .in_addr    (in_addr)
    );

    assign in_cmd = icmd;

endmodule

// File: rtl/mesi_line_ctrl_chk.sv
module mesi_line_ctrl_chk
    import mesi_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       loc_ready,
    input logic       loc_done,
    input logic       snp_hit,
    input logic       snp_hitm,
    input logic       backoff,
    input logic       bus_rd,
    input logic       bus_wr,
    input logic       bus_ack,
    input logic [2:0] in_cmd
);
    AST_HITM_HAS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        snp_hitm |-> snp_hit); // R4

    AST_BACKOFF_WITH_HITM: assert property (@(posedge clk) disable iff (!rst_n)
        backoff |-> snp_hitm); // R6

    AST_NO_LOCAL_IN_BACKOFF: assert property (@(posedge clk) disable iff (!rst_n)
        backoff |-> (!loc_ready && !loc_done)); // R10

    AST_RELEASE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(backoff) |-> $past(bus_ack)); // R4

    AST_FLUSH_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(backoff) |-> (!bus_wr && (in_cmd == ICMD_FLUSH_KEEP || in_cmd == ICMD_FLUSH_DROP))); // R6

    AST_INVAL_NO_BACKOFF: assert property (@(posedge clk) disable iff (!rst_n)
        (in_cmd == ICMD_INVAL) |-> !backoff); // R5

    AST_WBMODE_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_cmd == ICMD_WBMODE) |-> (!bus_wr && !bus_rd && loc_done)); // R7

    AST_SINGLE_BUS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr)); // R9

endmodule

bind mesi_line_ctrl mesi_line_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .loc_ready (loc_ready),
    .loc_done  (loc_done),
    .snp_hit   (snp_hit),
    .snp_hitm  (snp_hitm),
    .backoff   (backoff),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_ack   (bus_ack),
    .in_cmd    (in_cmd)
);

// File: tb/tb_mesi_line_ctrl.sv
`timescale 1ns/100ps
module tb_mesi_line_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        loc_req = 0, loc_we = 0, snp_valid = 0, snp_we = 0;
    logic        bus_ack = 0, bus_shared = 0, in_ack = 0;
    logic [11:0] loc_addr = '0, snp_addr = '0;
    logic        loc_ready, loc_done, snp_hit, snp_hitm, backoff, bus_rd, bus_wr;
    logic [11:0] bus_addr, in_addr;
    logic [2:0]  in_cmd;

    int n_chk = 0;
    int n_fail = 0;
    logic        r_now, r_rd, r_wr;
    logic [2:0]  r_cmd;
    logic [11:0] r_baddr;

    always #2 clk = ~clk;

    mesi_line_ctrl dut (
        .clk(clk), .rst_n(rst_n), .loc_req(loc_req), .loc_we(loc_we),
        .loc_addr(loc_addr), .loc_ready(loc_ready), .loc_done(loc_done),
        .snp_valid(snp_valid), .snp_we(snp_we), .snp_addr(snp_addr),
        .snp_hit(snp_hit), .snp_hitm(snp_hitm), .backoff(backoff),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_ack(bus_ack), .bus_shared(bus_shared), .in_cmd(in_cmd),
        .in_addr(in_addr), .in_ack(in_ack)
    );

    task automatic chk(input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    // Local request; bus handshake served when the request did not finish at once
    task automatic local_op(input logic we, input logic [11:0] a, input logic sh, input string tag);
        @(negedge clk);
        loc_req = 1; loc_we = we; loc_addr = a;
        #1;
        r_now = loc_done; r_cmd = in_cmd; r_rd = 0; r_wr = 0; r_baddr = '0;
        chk({tag, " loc_ready"}, loc_ready, 1);
        @(negedge clk);
        loc_req = 0;
        #1;
        if (!r_now) begin
            r_rd = bus_rd; r_wr = bus_wr; r_baddr = bus_addr;
            chk({tag, " no done before ack"}, loc_done, 0);
            bus_ack = 1; bus_shared = sh;
            #0.5;
            chk({tag, " done on ack"}, loc_done, 1);
            @(negedge clk);
            bus_ack = 0; bus_shared = 0;
        end
    endtask

    task automatic snoop(input logic we, input logic [11:0] a, input logic eh, input logic ehm,
                         input int ecmd, input logic hold, input string tag);
        @(negedge clk);
        snp_valid = 1; snp_we = we; snp_addr = a;
        #1;
        chk({tag, " snp_hit"}, snp_hit, eh);
        chk({tag, " snp_hitm"}, snp_hitm, ehm);
        chk({tag, " no backoff in snoop cycle"}, backoff, 0);
        chk({tag, " in_cmd"}, in_cmd, ecmd);
        if (ecmd == 3) chk({tag, " in_addr"}, in_addr, a);
        @(negedge clk);
        snp_valid = 0;
        if (ehm) begin
            if (hold) begin loc_req = 1; loc_we = 0; loc_addr = a; end
            #1;
            chk({tag, " backoff up"}, backoff, 1);
            chk({tag, " flush cmd"}, in_cmd, we ? 2 : 1);
            chk({tag, " no wb before flush"}, bus_wr, 0);
            if (hold) begin
                chk("R10 loc_ready low in flush", loc_ready, 0);
                chk("R10 loc_done low in flush", loc_done, 0);
            end
            @(negedge clk);
            #1;
            chk({tag, " flush held"}, in_cmd, we ? 2 : 1);
            in_ack = 1;
            @(negedge clk);
            in_ack = 0;
            #1;
            chk({tag, " write-back"}, bus_wr, 1);
            chk({tag, " wb addr"}, bus_addr, a);
            chk({tag, " backoff held"}, backoff, 1);
            if (hold) begin
                chk("R10 loc_ready low in wb", loc_ready, 0);
                chk("R10 no fill in wb", bus_rd, 0);
            end
            bus_ack = 1;
            @(negedge clk);
            bus_ack = 0; loc_req = 0;
            #1;
            chk({tag, " backoff released"}, backoff, 0);
        end
    endtask

    task automatic t_reset();
        chk("R1 reset backoff", backoff, 0);
        chk("R1 reset bus", bus_rd | bus_wr, 0);
        chk("R1 reset in_cmd", in_cmd, 0);
        snoop(0, 12'h013, 0, 0, 0, 0, "R1 snoop after reset");
        local_op(0, 12'h013, 0, "R1 read after reset");
        chk("R1 read misses", r_rd, 1);
        chk("R1 fill addr", r_baddr, 12'h013);
    endtask

    task automatic t_exclusive_path();
        local_op(0, 12'h013, 0, "R12 read hit");
        chk("R12 read hit immediate", r_now, 1);
        local_op(1, 12'h013, 0, "R7 write E");
        chk("R7 immediate", r_now, 1);
        chk("R7 wbmode cmd", r_cmd, 4);
        snoop(0, 12'h013, 1, 1, 0, 0, "R4 snoop read M");
        local_op(1, 12'h013, 0, "R8 write S after R4");
        chk("R8 write through to bus", r_wr, 1);
        chk("R8 no wbmode", r_cmd, 0);
        snoop(1, 12'h013, 1, 0, 3, 0, "R5 snoop write E");
        local_op(0, 12'h013, 0, "R5 read after inval");
        chk("R5 line invalid", r_rd, 1);
    endtask

    task automatic t_shared_fill();
        local_op(0, 12'h025, 1, "R2 shared fill");
        chk("R2 read issued", r_rd, 1);
        local_op(1, 12'h025, 0, "R2 write on S");
        chk("R2 filled as S so bus write", r_wr, 1);
        snoop(0, 12'h025, 1, 0, 0, 0, "R3 snoop read E");
        local_op(1, 12'h025, 0, "R3 write after downgrade");
        chk("R3 line now S", r_wr, 1);
        snoop(1, 12'h025, 1, 0, 3, 0, "R5 snoop write S");
    endtask

    task automatic t_snoop_write_mod();
        local_op(0, 12'h046, 0, "R6 fill");
        local_op(1, 12'h046, 0, "R6 make M");
        chk("R6 M via wbmode", r_cmd, 4);
        snoop(1, 12'h046, 1, 1, 0, 0, "R6 snoop write M");
        snoop(0, 12'h046, 0, 0, 0, 0, "R6 line invalid after");
    endtask

    task automatic t_write_miss();
        local_op(1, 12'h067, 0, "R9 write miss");
        chk("R9 bus write", r_wr, 1);
        chk("R9 no read", r_rd, 0);
        chk("R9 no inner cmd", r_cmd, 0);
        snoop(0, 12'h067, 0, 0, 0, 0, "R9 not allocated");
        local_op(0, 12'h067, 0, "R9 read after");
        chk("R9 still invalid", r_rd, 1);
    endtask

    task automatic t_backoff_block();
        local_op(0, 12'h0A4, 0, "R10 fill");
        local_op(1, 12'h0A4, 0, "R10 make M");
        snoop(0, 12'h0A4, 1, 1, 0, 1, "R10 snoop read M");
        local_op(0, 12'h0A4, 0, "R10 read after");
        chk("R10 line shared hit", r_now, 1);
    endtask

    task automatic t_snoop_miss();
        local_op(0, 12'h0F0, 0, "R11 fill");
        snoop(0, 12'h1F0, 0, 0, 0, 0, "R11 read other tag");
        snoop(1, 12'h1F0, 0, 0, 0, 0, "R11 write other tag");
        local_op(1, 12'h0F0, 0, "R11 still E");
        chk("R11 wbmode proves E", r_cmd, 4);
        chk("R11 no bus", r_wr, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        t_reset();
        t_exclusive_path();
        t_shared_fill();
        t_snoop_write_mod();
        t_write_miss();
        t_backoff_block();
        t_snoop_miss();
        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule